// File: doc/BRIEF.md
# Framebuffer Scan Address Generator

This block walks the active area of a linear framebuffer and produces one byte address per 64-bit memory beat for a display controller's pixel fetch path. Software supplies a base address, a visible width and height in pixels and a pixel size code. On a start pulse the block latches these settings and computes the row pitch in 8-byte words. It then issues requests row by row over a valid/ready handshake, one beat per accepted request.

The pitch is found by multiplying the width by the bytes per pixel first and then rounding the byte count up to a whole number of 8-byte words. Dividing the width by eight before multiplying would drop pixels and misalign rows whose width is not a multiple of eight pixels. For example, 540 pixels at 4 bytes give 0x10E words. The unused tail of a stored row, past the last visible pixel's word, is never requested. Each beat is marked end-of-line when it is the last beat of its row, and end-of-frame when it is also in the last row.

Top module: `fbscan_top`

## Requirements
- R1: While reset is applied and after it is released with no start pulse, req_valid, req_eol and req_eof are low.
- R2: The pitch in words equals ceil(xres × B / 8), where cfg_bpp codes 0, 1, 2, 3 select B = 1, 2, 4, 8 bytes per pixel (540 pixels at code 2 give 0x10E words).
- R3: The beat at word x of row y carries the address base + y × pitch × 8 + x × 8, with the three low bits of cfg_base taken as zero.
- R4: A frame holds exactly yres rows of pitch beats each, and req_valid falls in the cycle after the last beat is accepted.
- R5: req_eol is high only on the last beat of each row, req_eof only on the last beat of the last row, and neither is high while req_valid is low.
- R6: While req_valid is high and req_ready is low, req_valid, req_addr, req_eol and req_eof hold their values into the next cycle.
- R7: A start pulse sampled while no frame is in progress begins a frame, and req_valid rises in the following cycle; a start pulse during a frame is ignored.
- R8: The configuration is captured at the accepted start; changes to the configuration inputs during a frame do not alter that frame's addresses or markers.
- R9: A start pulse with cfg_xres or cfg_yres equal to zero starts no frame and req_valid stays low.
- R10: Every issued address is a multiple of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a frame |
| cfg_base | input | ADDR_W | Framebuffer byte base address |
| cfg_xres | input | XRES_W | Visible width in pixels |
| cfg_yres | input | YRES_W | Visible height in rows |
| cfg_bpp | input | 2 | Pixel size code, B = 2^code bytes |
| req_ready | input | 1 | Memory side accepts the current beat |
| req_valid | output | 1 | A beat request is presented |
| req_addr | output | ADDR_W | Byte address of the beat |
| req_eol | output | 1 | Beat is the last of its row |
| req_eof | output | 1 | Beat is the last of the frame |

## Verification
Two events can fall in one cycle here: a start pulse together with new configuration values arriving while a frame is still being fetched, and the final beat of a row coinciding with the final row, so that end-of-line and end-of-frame rise together. The bench provokes the first by pulsing start and changing width and base on the third cycle of selected frames. It judges the outcome by requiring every later address to follow the settings latched at the original start. The second case occurs on every frame of a sweep over widths, heights and all four pixel sizes under a pseudo-random ready pattern. There the bench checks that both markers rise on the same beat and that req_valid falls right after it.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;
   typedef enum logic [1:0] {
      PIX_1B = 2'd0,
      PIX_2B = 2'd1,
      PIX_4B = 2'd2,
      PIX_8B = 2'd3
   } pix_size_t;

   localparam int unsigned BEAT_BYTES = 8;
   localparam int unsigned BEAT_SHIFT = 3;
   localparam int unsigned NUM_SIZES  = 4;
endpackage

// File: rtl/fbscan_pitch.sv
module fbscan_pitch
   import fbscan_pkg::*;
#(
   parameter int unsigned XRES_W = 12
) (
   input  logic [XRES_W-1:0] xres,
   input  pix_size_t         size,
   output logic [XRES_W-1:0] words
);
   localparam int unsigned PROD_W = XRES_W + BEAT_SHIFT;

   logic [PROD_W-1:0] prod [NUM_SIZES];
   logic [PROD_W-1:0] sel_prod;
   logic [PROD_W-1:0] rounded;

   // byte count of one row for each pixel size, multiply before dividing
   generate
      for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
         assign prod[g] = {{BEAT_SHIFT{1'b0}}, xres} << g;
      end
   endgenerate

   assign sel_prod = prod[size];
   assign rounded  = sel_prod + PROD_W'(BEAT_BYTES - 1);
   assign words    = rounded[PROD_W-1:BEAT_SHIFT];
endmodule

// File: rtl/fbscan_cnt.sv
module fbscan_cnt #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] limit,
   output logic [W-1:0] value,
   output logic         last
);
   assign last = (value == limit - W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value <= '0;
      end else if (clr) begin
         value <= '0;
      end else if (inc) begin
         value <= last ? '0 : value + W'(1);
      end
   end
endmodule

// File: rtl/fbscan_top.sv
module fbscan_top
   import fbscan_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned XRES_W = 12,
   parameter int unsigned YRES_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [XRES_W-1:0] cfg_xres,
   input  logic [YRES_W-1:0] cfg_yres,
   input  logic [1:0]        cfg_bpp,
   input  logic              req_ready,
   output logic              req_valid,
   output logic [ADDR_W-1:0] req_addr,
   output logic              req_eol,
   output logic              req_eof
);
   generate
      if (ADDR_W < XRES_W + BEAT_SHIFT + 1) begin : g_chk_addr
         $error("fbscan_top: ADDR_W too narrow for XRES_W");
      end
      if (XRES_W < 1 || YRES_W < 1) begin : g_chk_res
         $error("fbscan_top: resolution widths must be positive");
      end
   endgenerate

   logic              active_q;
   logic [ADDR_W-1:0] row_addr_q;
   logic [XRES_W-1:0] pitch_q;
   logic [YRES_W-1:0] yres_q;
   logic [XRES_W-1:0] pitch_new;
   logic [XRES_W-1:0] x_val;
   logic [YRES_W-1:0] y_val;
   logic              x_last;
   logic              y_last;
   logic              start_ok;
   logic              fire;
   logic              row_done;
   logic              frame_done;
   logic [ADDR_W-1:0] pitch_bytes;

   assign start_ok   = start && !active_q && (cfg_xres != '0) && (cfg_yres != '0);
   assign fire       = active_q && req_ready;
   assign row_done   = fire && x_last;
   assign frame_done = row_done && y_last;

   fbscan_pitch #(.XRES_W(XRES_W)) u_pitch (
      .xres  (cfg_xres),
      .size  (pix_size_t'(cfg_bpp)),
      .words (pitch_new)
   );

   fbscan_cnt #(.W(XRES_W)) u_xcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_ok),
      .inc   (fire),
      .limit (pitch_q),
      .value (x_val),
      .last  (x_last)
   );

   fbscan_cnt #(.W(YRES_W)) u_ycnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_ok),
      .inc   (row_done),
      .limit (yres_q),
      .value (y_val),
      .last  (y_last)
   );

   assign pitch_bytes = ADDR_W'(pitch_q) << BEAT_SHIFT;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q   <= 1'b0;
         row_addr_q <= '0;
         pitch_q    <= '0;
         yres_q     <= '0;
      end else if (start_ok) begin
         active_q   <= 1'b1;
         row_addr_q <= {cfg_base[ADDR_W-1:BEAT_SHIFT], {BEAT_SHIFT{1'b0}}};
         pitch_q    <= pitch_new;
         yres_q     <= cfg_yres;
      end else begin
         if (frame_done) begin
            active_q <= 1'b0;
         end
         if (row_done) begin
            row_addr_q <= row_addr_q + pitch_bytes;
         end
      end
   end

   assign req_valid = active_q;
   assign req_addr  = row_addr_q + (ADDR_W'(x_val) << BEAT_SHIFT);
   assign req_eol   = active_q && x_last;
   assign req_eof   = active_q && x_last && y_last;
endmodule

// File: rtl/fbscan_chk.sv
module fbscan_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_eol,
   input logic              req_eof
);
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_eol) && $stable(req_eof)); // R6

   AST_EOF_WITH_EOL: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_eof |-> req_eol); // R5

   AST_IDLE_NO_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !req_eol && !req_eof); // R5

   AST_FRAME_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_eof |=> !req_valid); // R4

   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_addr[2:0] == 3'b000); // R10

   AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !req_eol |=> req_valid && req_addr == $past(req_addr) + ADDR_W'(8)); // R3
endmodule

bind fbscan_top fbscan_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .req_valid (req_valid),
   .req_addr  (req_addr),
   .req_eol   (req_eol),
   .req_eof   (req_eof)
);

// File: tb/fbscan_tb.sv
module fbscan_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] cfg_base = '0;
   logic [11:0] cfg_xres = '0;
   logic [11:0] cfg_yres = '0;
   logic [1:0]  cfg_bpp = '0;
   logic        req_ready = 1'b0;
   logic        req_valid;
   logic [31:0] req_addr;
   logic        req_eol;
   logic        req_eof;

   int nvec  = 0;
   int nfail = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #(CLK_PERIOD/2) clk = ~clk;

   fbscan_top dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cfg_base  (cfg_base),
      .cfg_xres  (cfg_xres),
      .cfg_yres  (cfg_yres),
      .cfg_bpp   (cfg_bpp),
      .req_ready (req_ready),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_eol   (req_eol),
      .req_eof   (req_eof)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
   endtask

   // one frame; disturb pulses start with new settings mid-frame (R7, R8)
   task automatic run_frame(input logic [31:0] b, input int xr, input int yr,
                            input int sel, input bit disturb);
      int pw = (xr * (1 << sel) + 7) / 8;
      int bx = 0;
      int by = 0;
      int cyc = 0;
      logic [31:0] base_al = b & ~32'h7;
      logic [31:0] exp_addr;
      logic [31:0] prev_addr = '0;
      bit prev_stall = 0;
      @(negedge clk);
      cfg_base = b; cfg_xres = 12'(xr); cfg_yres = 12'(yr); cfg_bpp = 2'(sel);
      start = 1'b1; req_ready = 1'b0;
      @(negedge clk);
      start = 1'b0;
      if (xr == 0 || yr == 0) begin
         for (int i = 0; i < 3; i++) begin
            chk(!req_valid, "R9", "valid after zero-size start", 32'(req_valid), 0);
            @(negedge clk);
         end
         return;
      end
      chk(req_valid, "R7", "valid after start", 32'(req_valid), 1);
      while (by < yr) begin
         exp_addr = base_al + 32'(by * pw * 8) + 32'(bx * 8);
         chk(req_valid, "R4", "valid inside frame", 32'(req_valid), 1);
         if (prev_stall)
            chk(req_addr == prev_addr, "R6", "addr held under stall", req_addr, prev_addr);
         if (bx == 0 && by > 0)
            chk(req_addr == exp_addr, "R2", "row start uses rounded pitch", req_addr, exp_addr);
         else
            chk(req_addr == exp_addr, "R3", "beat address", req_addr, exp_addr);
         chk(req_addr[2:0] == 3'b0, "R10", "alignment", 32'(req_addr[2:0]), 0);
         chk(req_eol == (bx == pw - 1), "R5", "eol marker", 32'(req_eol), 32'(bx == pw - 1));
         chk(req_eof == (bx == pw - 1 && by == yr - 1), "R5", "eof marker",
             32'(req_eof), 32'(bx == pw - 1 && by == yr - 1));
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         req_ready = lfsr[0] | lfsr[1];
         if (disturb && cyc == 2) begin
            start = 1'b1;
            cfg_xres = 12'(xr + 4);
            cfg_base = b ^ 32'h1000;
            cfg_yres = 12'(yr + 1);
         end else begin
            start = 1'b0;
         end
         prev_stall = !req_ready;
         prev_addr = req_addr;
         if (req_ready) begin
            bx++;
            if (bx == pw) begin bx = 0; by++; end
         end
         @(negedge clk);
         cyc++;
      end
      req_ready = 1'b0; start = 1'b0;
      chk(!req_valid, "R4", "valid falls after last beat", 32'(req_valid), 0);
      chk(!req_eol && !req_eof, "R5", "markers low when idle", 32'({req_eol, req_eof}), 0);
      @(negedge clk);
      chk(!req_valid, "R4", "no extra beats", 32'(req_valid), 0);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WD_CYCLES);
      summary();
      $finish;
   end

   initial begin
      int xs [10] = '{1, 2, 3, 5, 7, 8, 9, 17, 33, 540};
      repeat (3) @(negedge clk);
      chk(!req_valid && !req_eol && !req_eof, "R1", "outputs in reset",
          32'({req_valid, req_eol, req_eof}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!req_valid, "R1", "idle after reset", 32'(req_valid), 0);

      // zero-size starts (R9)
      run_frame(32'h100, 0, 4, 2, 0);
      run_frame(32'h100, 6, 0, 1, 0);

      // 540 pixels at 4 bytes: pitch 0x10E words (R2)
      run_frame(32'h0004_0000, 540, 2, 2, 0);

      for (int s = 0; s < 4; s++)
         for (int i = 0; i < 10; i++)
            for (int y = 1; y <= 3; y++)
               run_frame(32'h0010_0000 + 32'(s * 32'h1_0000) + 32'(i * 32'h100) + 32'(y),
                         xs[i], y, s, (y == 2));

      // mid-frame start and settings change on a short frame (R7, R8)
      run_frame(32'h0000_2005, 3, 3, 3, 1);

      summary();
      $finish;
   end
endmodule